// File: doc/BRIEF.md
# Pipeline forwarding and interlock unit

This block is the hazard control for a five-stage integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it receives the decoded shape of the instruction sitting in the fetch/decode register. It keeps its own copy of the control slots for the three later pipeline registers: decode/execute, execute/memory and memory/writeback. Each slot holds the register fields and the write enables. From these slots it works out where every operand of the instruction in execute must come from. The choices are the register file, the execute/memory ALU result, the memory/writeback ALU result or the memory/writeback load data. It also says whether a store in the memory stage must take its write data from the load that has just completed.

Forwarding cannot cover one case: a load in execute whose target register is read by the very next instruction. For this case the unit raises a hold for the program counter and the fetch/decode register. In the same cycle it turns the slot entering execute into a bubble. The bubble keeps moving down the pipe with its register-write and memory-write enables off, so it performs no work that is saved. The datapath (ALU, memories, register file, branch logic) lives outside and follows the select and hold outputs.

Top module: `fwd_interlock_unit`

## Requirements
- R1: An operand select is 2 bits: 0 register file, 1 execute/memory ALU result, 2 memory/writeback ALU result, 3 memory/writeback load data. A source register that equals the destination of a register-writing non-load instruction in execute/memory gives select 1. This applies to operand A (rs), operand B (rt of a register-register op) and store data (rt of a store).
- R2: When execute/memory does not match, a source register that equals the destination of a register-writing ALU instruction in memory/writeback gives select 2.
- R3: When execute/memory does not match, a source that equals the target of a load in memory/writeback gives select 3. In addition, `mem_st_from_load` is 1 whenever a store in execute/memory names in rt the target of the load in memory/writeback.
- R4: A match in execute/memory takes priority over a match in memory/writeback. If the execute/memory match is a load (reachable only for store data), the select is 0 and the store picks up the value one stage later through `mem_st_from_load`.
- R5: A destination of register 0 never matches. It causes no forwarding and no hold.
- R6: `front_hold` is 1 when a load with a non-zero target sits in execute and the instruction in decode reads that register through rs (any kind that reads rs) or through rt as a register-register operand. A store that reads it only as rt data causes no hold. The hold lasts exactly one cycle.
- R7: After a hold cycle, the execute slot is a bubble: `ex_reg_we` = 0, `ex_mem_we` = 0 and all execute selects are 0. The older load still advances into the memory stage. The bubble reaches memory and writeback with its enables still off.
- R8: The kind code `id_kind` is 0 no-op, 1 register-register ALU (destination rd, reads rs and rt), 2 register-immediate ALU (destination rt, reads rs), 3 load (destination rt, reads rs), 4 store (reads rs and rt, writes memory, writes no register). A no-op writes nothing.
- R9: While `rst_n` is low at a clock edge, all slots clear. After that edge, every write enable, every select and `front_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_kind | input | 3 | Kind code of the instruction in decode |
| id_rs | input | REG_AW | rs field of the instruction in decode |
| id_rt | input | REG_AW | rt field of the instruction in decode |
| id_rd | input | REG_AW | rd field of the instruction in decode |
| front_hold | output | 1 | Hold program counter and fetch/decode register; bubble enters execute |
| ex_sel_a | output | 2 | Operand A source select for the instruction in execute |
| ex_sel_b | output | 2 | Operand B source select for the instruction in execute |
| ex_sel_st | output | 2 | Store-data source select for the instruction in execute |
| mem_st_from_load | output | 1 | Store in memory stage takes write data from the load in writeback |
| ex_reg_we | output | 1 | Register-write enable of the execute slot |
| ex_mem_we | output | 1 | Memory-write enable of the execute slot |
| mem_reg_we | output | 1 | Register-write enable of the memory slot |
| mem_mem_we | output | 1 | Memory-write enable of the memory slot |
| wb_reg_we | output | 1 | Register-write enable of the writeback slot |
| wb_dest | output | REG_AW | Destination register of the writeback slot |

## Verification
The bench builds the unit with the default `REG_AW` of 5, which gives 32 architectural registers. With this width, register 0 and distinct, non-aliasing registers are available to every directed sequence. The bench acts as the surrounding pipeline: while `front_hold` is high it keeps the decode instruction steady. This lets it follow a load-use stall cycle by cycle, from the hold through the bubble reaching writeback. Priority, shadowing by a load in execute/memory, and the late store-data path are each reached by short dedicated sequences.

// File: rtl/fwd_pkg.sv
// Shared constants and types for the forwarding and interlock unit.
// Assumes a three-slot control pipe (ID/EX, EX/MEM, MEM/WB) and three
// forwarded operands per instruction in execute.
package fwd_pkg;

    localparam int KIND_W = 3;
    localparam int SEL_W  = 2;
    localparam int NSTAGE = 3;
    localparam int NOPND  = 3;

    // Slot indices inside the control pipe
    localparam int ST_EX  = 0;
    localparam int ST_MEM = 1;
    localparam int ST_WB  = 2;

    // Operand indices
    localparam int OP_A  = 0;
    localparam int OP_B  = 1;
    localparam int OP_ST = 2;

    typedef enum logic [KIND_W-1:0] {
        K_NOP   = 3'd0,
        K_RR    = 3'd1,
        K_RI    = 3'd2,
        K_LOAD  = 3'd3,
        K_STORE = 3'd4
    } ikind_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF       = 2'd0,
        SEL_EXM_ALU  = 2'd1,
        SEL_MWB_ALU  = 2'd2,
        SEL_MWB_LOAD = 2'd3
    } fsel_e;

    typedef struct packed {
        logic reg_we;
        logic mem_we;
        logic is_load;
        logic use_rs;
        logic use_rt_alu;
        logic use_rt_st;
    } slot_flags_t;

endpackage

// File: rtl/fwd_decode.sv
// Turns the kind code of the decode-stage instruction into control flags
// and a destination register. Assumes kind codes outside the enum are no-ops.
module fwd_decode
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [KIND_W-1:0] kind_raw,
    input  logic [REG_AW-1:0] rt,
    input  logic [REG_AW-1:0] rd,
    output slot_flags_t       flags,
    output logic [REG_AW-1:0] dest
);

    // Map kind to write enables, operand usage and destination field
    always_comb begin
        flags = '0;
        dest  = '0;
        case (ikind_e'(kind_raw))
            K_RR: begin
                flags.reg_we     = 1'b1;
                flags.use_rs     = 1'b1;
                flags.use_rt_alu = 1'b1;
                dest             = rd;
            end
            K_RI: begin
                flags.reg_we = 1'b1;
                flags.use_rs = 1'b1;
                dest         = rt;
            end
            K_LOAD: begin
                flags.reg_we  = 1'b1;
                flags.is_load = 1'b1;
                flags.use_rs  = 1'b1;
                dest          = rt;
            end
            K_STORE: begin
                flags.mem_we    = 1'b1;
                flags.use_rs    = 1'b1;
                flags.use_rt_st = 1'b1;
            end
            default: begin
                flags = '0;
                dest  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fwd_slot_pipe.sv
// Control slots for ID/EX, EX/MEM and MEM/WB. Slot 0 loads the decoded
// instruction or, when bubble is set, a copy with every enable and usage
// flag cleared. Later slots always advance. Synchronous active-low reset.
module fwd_slot_pipe
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DEPTH  = NSTAGE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bubble,
    input  slot_flags_t       in_flags,
    input  logic [REG_AW-1:0] in_rs,
    input  logic [REG_AW-1:0] in_rt,
    input  logic [REG_AW-1:0] in_dst,
    output slot_flags_t       flg_q [DEPTH],
    output logic [REG_AW-1:0] rs_q  [DEPTH],
    output logic [REG_AW-1:0] rt_q  [DEPTH],
    output logic [REG_AW-1:0] dst_q [DEPTH]
);

    // Entry slot: capture decode or insert a bubble that saves nothing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q[0] <= '0;
            rs_q[0]  <= '0;
            rt_q[0]  <= '0;
            dst_q[0] <= '0;
        end else begin
            flg_q[0] <= bubble ? slot_flags_t'('0) : in_flags;
            rs_q[0]  <= in_rs;
            rt_q[0]  <= in_rt;
            dst_q[0] <= in_dst;
        end
    end

    // Later slots: unconditional advance from the previous slot
    for (genvar s = 1; s < DEPTH; s++) begin : g_adv
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flg_q[s] <= '0;
                rs_q[s]  <= '0;
                rt_q[s]  <= '0;
                dst_q[s] <= '0;
            end else begin
                flg_q[s] <= flg_q[s-1];
                rs_q[s]  <= rs_q[s-1];
                rt_q[s]  <= rt_q[s-1];
                dst_q[s] <= dst_q[s-1];
            end
        end
    end

endmodule

// File: rtl/fwd_select.sv
// Source select for one operand of the instruction in execute. The younger
// EX/MEM slot wins. A load in EX/MEM shadows older results and yields the
// register-file code. Register 0 never matches.
module fwd_select
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              use_src,
    input  logic [REG_AW-1:0] src,
    input  slot_flags_t       exm_flags,
    input  logic [REG_AW-1:0] exm_dst,
    input  slot_flags_t       mwb_flags,
    input  logic [REG_AW-1:0] mwb_dst,
    output logic [SEL_W-1:0]  sel
);

    logic exm_hit;
    logic mwb_hit;

    // Compare the source against both later destinations
    always_comb begin
        exm_hit = use_src && exm_flags.reg_we && (exm_dst != '0) && (exm_dst == src);
        mwb_hit = use_src && mwb_flags.reg_we && (mwb_dst != '0) && (mwb_dst == src);
    end

    // Encode the select with younger-first priority
    always_comb begin
        if (exm_hit) begin
            sel = exm_flags.is_load ? SEL_RF : SEL_EXM_ALU;
        end else if (mwb_hit) begin
            sel = mwb_flags.is_load ? SEL_MWB_LOAD : SEL_MWB_ALU;
        end else begin
            sel = SEL_RF;
        end
    end

endmodule

// File: rtl/fwd_interlock.sv
// Load-use detector. Raises hold when a load in execute writes a register
// that the decode instruction needs in execute (rs, or rt of a
// register-register op). Store data through rt is served later and
// does not hold.
module fwd_interlock
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  slot_flags_t       id_flags,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  slot_flags_t       ex_flags,
    input  logic [REG_AW-1:0] ex_dst,
    output logic              hold
);

    logic ld_live;
    logic rs_dep;
    logic rt_dep;

    // Detect a live load and a dependent read in decode
    always_comb begin
        ld_live = ex_flags.is_load && ex_flags.reg_we && (ex_dst != '0);
        rs_dep  = id_flags.use_rs && (id_rs == ex_dst);
        rt_dep  = id_flags.use_rt_alu && (id_rt == ex_dst);
        hold    = ld_live && (rs_dep || rt_dep);
    end

endmodule

// File: rtl/fwd_interlock_unit.sv
// Top of the forwarding and interlock unit. Decodes the decode-stage
// instruction, keeps control slots for the three later pipeline registers,
// produces operand selects and the late store-data select, and holds the
// front of the pipe for one cycle on a load-use dependency. Assumes the
// surrounding pipeline keeps the decode instruction steady while front_hold
// is high.
module fwd_interlock_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] id_kind,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] id_rd,
    output logic              front_hold,
    output logic [SEL_W-1:0]  ex_sel_a,
    output logic [SEL_W-1:0]  ex_sel_b,
    output logic [SEL_W-1:0]  ex_sel_st,
    output logic              mem_st_from_load,
    output logic              ex_reg_we,
    output logic              ex_mem_we,
    output logic              mem_reg_we,
    output logic              mem_mem_we,
    output logic              wb_reg_we,
    output logic [REG_AW-1:0] wb_dest
);

    slot_flags_t       id_flags;
    logic [REG_AW-1:0] id_dst;

    slot_flags_t       flg_q [NSTAGE];
    logic [REG_AW-1:0] rs_q  [NSTAGE];
    logic [REG_AW-1:0] rt_q  [NSTAGE];
    logic [REG_AW-1:0] dst_q [NSTAGE];

    logic              op_use [NOPND];
    logic [REG_AW-1:0] op_src [NOPND];
    logic [SEL_W-1:0]  op_sel [NOPND];

    fwd_decode #(.REG_AW(REG_AW)) u_dec (
        .kind_raw (id_kind),
        .rt       (id_rt),
        .rd       (id_rd),
        .flags    (id_flags),
        .dest     (id_dst)
    );

    fwd_interlock #(.REG_AW(REG_AW)) u_lock (
        .id_flags (id_flags),
        .id_rs    (id_rs),
        .id_rt    (id_rt),
        .ex_flags (flg_q[ST_EX]),
        .ex_dst   (dst_q[ST_EX]),
        .hold     (front_hold)
    );

    fwd_slot_pipe #(.REG_AW(REG_AW), .DEPTH(NSTAGE)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .bubble   (front_hold),
        .in_flags (id_flags),
        .in_rs    (id_rs),
        .in_rt    (id_rt),
        .in_dst   (id_dst),
        .flg_q    (flg_q),
        .rs_q     (rs_q),
        .rt_q     (rt_q),
        .dst_q    (dst_q)
    );

    // Route each execute operand's usage flag and source register
    always_comb begin
        op_use[OP_A]  = flg_q[ST_EX].use_rs;
        op_src[OP_A]  = rs_q[ST_EX];
        op_use[OP_B]  = flg_q[ST_EX].use_rt_alu;
        op_src[OP_B]  = rt_q[ST_EX];
        op_use[OP_ST] = flg_q[ST_EX].use_rt_st;
        op_src[OP_ST] = rt_q[ST_EX];
    end

    for (genvar o = 0; o < NOPND; o++) begin : g_op
        fwd_select #(.REG_AW(REG_AW)) u_sel (
            .use_src   (op_use[o]),
            .src       (op_src[o]),
            .exm_flags (flg_q[ST_MEM]),
            .exm_dst   (dst_q[ST_MEM]),
            .mwb_flags (flg_q[ST_WB]),
            .mwb_dst   (dst_q[ST_WB]),
            .sel       (op_sel[o])
        );
    end

    // Late store-data path from completed load into the memory write port
    always_comb begin
        mem_st_from_load = flg_q[ST_MEM].mem_we && flg_q[ST_MEM].use_rt_st
                        && flg_q[ST_WB].is_load && flg_q[ST_WB].reg_we
                        && (dst_q[ST_WB] != '0) && (dst_q[ST_WB] == rt_q[ST_MEM]);
    end

    // Drive selects and per-stage enables to the datapath
    always_comb begin
        ex_sel_a   = op_sel[OP_A];
        ex_sel_b   = op_sel[OP_B];
        ex_sel_st  = op_sel[OP_ST];
        ex_reg_we  = flg_q[ST_EX].reg_we;
        ex_mem_we  = flg_q[ST_EX].mem_we;
        mem_reg_we = flg_q[ST_MEM].reg_we;
        mem_mem_we = flg_q[ST_MEM].mem_we;
        wb_reg_we  = flg_q[ST_WB].reg_we;
        wb_dest    = dst_q[ST_WB];
    end

endmodule

// File: rtl/fwd_interlock_chk.sv
// Property checker for fwd_interlock_unit, attached by bind. Observes only
// the top-level ports and relates them across cycles.
module fwd_interlock_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        id_kind,
    input logic [REG_AW-1:0] id_rs,
    input logic [REG_AW-1:0] id_rt,
    input logic [REG_AW-1:0] id_rd,
    input logic              front_hold,
    input logic [1:0]        ex_sel_a,
    input logic [1:0]        ex_sel_b,
    input logic [1:0]        ex_sel_st,
    input logic              mem_st_from_load,
    input logic              ex_reg_we,
    input logic              ex_mem_we,
    input logic              mem_reg_we,
    input logic              mem_mem_we,
    input logic              wb_reg_we,
    input logic [REG_AW-1:0] wb_dest
);

    logic any_exm;
    logic any_mwb_alu;
    logic any_mwb_ld;
    logic unused_ok;

    // Summaries of the select outputs
    always_comb begin
        any_exm     = (ex_sel_a == 2'd1) || (ex_sel_b == 2'd1) || (ex_sel_st == 2'd1);
        any_mwb_alu = (ex_sel_a == 2'd2) || (ex_sel_b == 2'd2) || (ex_sel_st == 2'd2);
        any_mwb_ld  = (ex_sel_a == 2'd3) || (ex_sel_b == 2'd3) || (ex_sel_st == 2'd3);
        unused_ok   = ^{id_kind, id_rs, id_rt, id_rd};
    end

    // R1: an EX/MEM forward needs a register-writing slot in memory
    a_r1_exm_writer: assert property (@(posedge clk) disable iff (!rst_n)
        any_exm |-> mem_reg_we);

    // R2 and R5: a MEM/WB ALU forward needs a writing slot with a non-zero target
    a_r2_mwb_writer: assert property (@(posedge clk) disable iff (!rst_n)
        any_mwb_alu |-> (wb_reg_we && wb_dest != '0));

    // R3 and R5: load-data forwarding needs a writing slot with a non-zero target
    a_r3_load_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (any_mwb_ld || mem_st_from_load) |-> (wb_reg_we && wb_dest != '0));

    // R3: the late store path only serves a store in memory
    a_r3_store_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_from_load |-> mem_mem_we);

    // R6: a hold lasts exactly one cycle
    a_r6_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |=> !front_hold);

    // R7: the slot entering execute after a hold saves nothing and selects nothing
    a_r7_bubble_ex: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |=> (!ex_reg_we && !ex_mem_we && ex_sel_a == 2'd0
                        && ex_sel_b == 2'd0 && ex_sel_st == 2'd0));

    // R7: the bubble keeps its enables off in memory
    a_r7_bubble_mem: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |=> ##1 (!mem_reg_we && !mem_mem_we));

    // R7: the bubble keeps its register write off in writeback
    a_r7_bubble_wb: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |=> ##2 !wb_reg_we);

    // R9: a reset edge clears every enable and the hold
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!ex_reg_we && !ex_mem_we && !mem_reg_we && !mem_mem_we
                    && !wb_reg_we && !front_hold));

endmodule

bind fwd_interlock_unit fwd_interlock_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/fwd_interlock_unit_test.sv
`timescale 1ns/100ps
module fwd_interlock_unit_test;
    import fwd_pkg::*;

    localparam int REG_AW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        id_kind = 3'd0;
    logic [REG_AW-1:0] id_rs = '0;
    logic [REG_AW-1:0] id_rt = '0;
    logic [REG_AW-1:0] id_rd = '0;
    logic              front_hold;
    logic [1:0]        ex_sel_a, ex_sel_b, ex_sel_st;
    logic              mem_st_from_load;
    logic              ex_reg_we, ex_mem_we, mem_reg_we, mem_mem_we, wb_reg_we;
    logic [REG_AW-1:0] wb_dest;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fwd_interlock_unit #(.REG_AW(REG_AW)) uut (
        .clk(clk), .rst_n(rst_n), .id_kind(id_kind), .id_rs(id_rs),
        .id_rt(id_rt), .id_rd(id_rd), .front_hold(front_hold),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .ex_sel_st(ex_sel_st),
        .mem_st_from_load(mem_st_from_load), .ex_reg_we(ex_reg_we),
        .ex_mem_we(ex_mem_we), .mem_reg_we(mem_reg_we),
        .mem_mem_we(mem_mem_we), .wb_reg_we(wb_reg_we), .wb_dest(wb_dest)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input ikind_e k, input int rs, input int rt, input int rd);
        @(negedge clk);
        id_kind = k;
        id_rs   = REG_AW'(rs);
        id_rt   = REG_AW'(rt);
        id_rd   = REG_AW'(rd);
        #0.5;
    endtask

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) begin
            push(K_NOP, 0, 0, 0);
            tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        push(K_RR, 1, 1, 1);
        tick();
        tick();
        check("R9", "ex_reg_we", ex_reg_we, 0);
        check("R9", "wb_reg_we", wb_reg_we, 0);
        check("R9", "sel_a", ex_sel_a, 0);
        check("R9", "hold", front_hold, 0);
        @(negedge clk);
        rst_n = 1'b1;
        flush();
    endtask

    task automatic t_alu_chain();
        flush();
        push(K_RR, 2, 3, 1);  tick();
        push(K_RR, 1, 5, 4);  tick();
        check("R1", "sub sel_a", ex_sel_a, 1);
        check("R1", "sub sel_b", ex_sel_b, 0);
        push(K_RR, 1, 7, 6);  tick();
        check("R2", "and sel_a", ex_sel_a, 2);
        push(K_RR, 1, 9, 8);  tick();
        check("R2", "or sel_a", ex_sel_a, 0);
        push(K_RR, 1, 11, 10); tick();
        check("R2", "xor sel_a", ex_sel_a, 0);
    endtask

    task automatic t_operand_b();
        flush();
        push(K_RR, 2, 3, 1);  tick();
        push(K_RR, 8, 8, 9);  tick();
        push(K_RR, 5, 1, 4);  tick();
        check("R2", "opB sel_b", ex_sel_b, 2);
        check("R2", "opB sel_a", ex_sel_a, 0);
    endtask

    task automatic t_priority();
        flush();
        push(K_RR, 2, 3, 1);  tick();
        push(K_RR, 4, 5, 1);  tick();
        push(K_RR, 1, 1, 6);  tick();
        check("R4", "younger sel_a", ex_sel_a, 1);
        check("R4", "younger sel_b", ex_sel_b, 1);
    endtask

    task automatic t_zero();
        flush();
        push(K_RR, 2, 3, 0);  tick();
        push(K_RR, 0, 0, 4);  tick();
        check("R5", "r0 sel_a", ex_sel_a, 0);
        check("R5", "r0 sel_b", ex_sel_b, 0);
        flush();
        push(K_LOAD, 2, 0, 0); tick();
        push(K_RR, 0, 5, 4);
        check("R5", "r0 load hold", front_hold, 0);
    endtask

    task automatic t_dest();
        flush();
        push(K_RI, 2, 7, 9);  tick();
        push(K_RR, 7, 9, 4);  tick();
        check("R8", "ri dest rt sel_a", ex_sel_a, 1);
        check("R8", "ri rd unused sel_b", ex_sel_b, 0);
        push(K_STORE, 3, 12, 12); tick();
        check("R8", "store ex_reg_we", ex_reg_we, 0);
        check("R8", "store ex_mem_we", ex_mem_we, 1);
        push(K_RR, 12, 12, 5); tick();
        check("R8", "after store sel_a", ex_sel_a, 0);
        check("R8", "after store sel_b", ex_sel_b, 0);
        check("R8", "rr ex_reg_we", ex_reg_we, 1);
    endtask

    task automatic t_load_use();
        flush();
        push(K_LOAD, 2, 1, 0); tick();
        push(K_RR, 1, 5, 4);
        check("R6", "load-use hold", front_hold, 1);
        tick();
        check("R7", "bubble ex_reg_we", ex_reg_we, 0);
        check("R7", "bubble ex_mem_we", ex_mem_we, 0);
        check("R7", "bubble sel_a", ex_sel_a, 0);
        check("R7", "load advanced mem_reg_we", mem_reg_we, 1);
        check("R6", "hold released", front_hold, 0);
        tick();
        check("R3", "after stall sel_a", ex_sel_a, 3);
        check("R7", "bubble mem_reg_we", mem_reg_we, 0);
        push(K_NOP, 0, 0, 0); tick();
        check("R7", "bubble wb_reg_we", wb_reg_we, 0);
    endtask

    task automatic t_hold_kinds();
        flush();
        push(K_LOAD, 2, 1, 0); tick();
        push(K_RR, 5, 1, 4);
        check("R6", "rt operand hold", front_hold, 1);
        flush();
        push(K_LOAD, 2, 1, 0); tick();
        push(K_STORE, 1, 6, 0);
        check("R6", "store base hold", front_hold, 1);
        flush();
        push(K_LOAD, 2, 1, 0); tick();
        push(K_STORE, 3, 1, 0);
        check("R6", "store data no hold", front_hold, 0);
        tick();
        check("R4", "store shadowed sel_st", ex_sel_st, 0);
        push(K_NOP, 0, 0, 0); tick();
        check("R3", "mem_st_from_load", mem_st_from_load, 1);
        check("R3", "mem_mem_we", mem_mem_we, 1);
    endtask

    task automatic t_load_gap();
        flush();
        push(K_LOAD, 2, 1, 0); tick();
        push(K_NOP, 0, 0, 0);
        check("R6", "nop no hold", front_hold, 0);
        tick();
        push(K_RR, 1, 5, 4);
        check("R6", "gap no hold", front_hold, 0);
        tick();
        check("R3", "gap sel_a", ex_sel_a, 3);
        flush();
        push(K_LOAD, 2, 1, 0); tick();
        push(K_NOP, 0, 0, 0);  tick();
        push(K_STORE, 3, 1, 0); tick();
        check("R3", "gap store sel_st", ex_sel_st, 3);
    endtask

    task automatic t_shadow();
        flush();
        push(K_RR, 2, 3, 1);   tick();
        push(K_LOAD, 4, 1, 0); tick();
        push(K_STORE, 3, 1, 0);
        check("R6", "shadow no hold", front_hold, 0);
        tick();
        check("R4", "load shadows alu sel_st", ex_sel_st, 0);
        push(K_NOP, 0, 0, 0); tick();
        check("R4", "late store path", mem_st_from_load, 1);
    endtask

    initial begin
        t_reset();
        t_alu_chain();
        t_operand_b();
        t_priority();
        t_zero();
        t_dest();
        t_load_use();
        t_hold_kinds();
        t_load_gap();
        t_shadow();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule